// File: doc/BRIEF.md
# Line Conflict Arbiter with Per-Port Pending Queues

The block sits in front of a shared cache controller and takes memory requests from four CPU ports in the same cycle. Each request has a 32-bit byte address and a 2-bit kind: 0 read, 1 write, 2 read-broadcast, 3 write-broadcast. Two requests collide when they fall on the same cache line, meaning the same address bits 31:4. The offset bits 3:0 play no part in the comparison. For each line, only the lowest-numbered port presenting it is granted. Every other port on that line keeps its request in a private pending queue.

Each port has one candidate per cycle. While its queue is empty, the candidate is the new request. Once the queue holds anything, the candidate is the oldest queued entry, and any new request from that port is appended behind it. Per-port order is therefore never broken. Each port has its own grant lane towards a downstream sink. All lanes share a single ready. The block also reports the occupancy of every queue. A port withdraws its ready when its queue is full or when the sink is not ready, so no request is ever lost.

Top module: `line_conflict_arbiter`

## Requirements
- R1: After a synchronous active-low reset, every occupancy is 0, no grant is valid while no request is presented, and every req_ready equals gnt_ready.
- R2: With empty queues and no two valid requests on the same line, every valid request is granted in the same cycle on its own lane, with the address and kind passed through unchanged.
- R3: Lines are compared on address bits 31:4 only. Among candidates on one line, port 0 has the highest priority and port 3 the lowest, and only the highest-priority candidate has gnt_valid set.
- R4: A request that is accepted (req_valid and req_ready both high) but not granted in that cycle raises its port's occupancy by exactly one.
- R5: A port with a non-empty queue presents the oldest entry first. A new accepted request is appended behind it, and grants on each lane come out in the order the requests were accepted.
- R6: A queue holds at most 16 entries. The port's req_ready is low while its occupancy is 16, and the occupancy stays at 16 while the port keeps requesting.
- R7: While gnt_ready is low, every req_ready is low and no occupancy changes. Lanes may still show gnt_valid, but nothing is consumed.
- R8: No two lanes assert gnt_valid for the same line in the same cycle.
- R9: Every accepted request is granted exactly once. After the queues drain, no further grant appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 4 | Request present, one bit per port |
| req_ready | output | 4 | Port can take a request this cycle |
| req_kind | input | 8 | Request kind, 2 bits per port, port 0 in bits 1:0 |
| req_addr | input | 128 | Byte address, 32 bits per port, port 0 in bits 31:0 |
| gnt_valid | output | 4 | Lane carries a granted request |
| gnt_ready | input | 1 | Sink takes all valid lanes this cycle |
| gnt_kind | output | 8 | Kind on each grant lane |
| gnt_addr | output | 128 | Address on each grant lane |
| occupancy | output | 20 | Queue depth 0..16, 5 bits per port |

## Verification
A table of cycles drives all four ports with distinct lines, with pairs on shared lines, and with all four on one line at different offsets. Together these separate a correct priority decision from one that compares the offset or picks the wrong winner. Later table rows replay queued heads against fresh arrivals and hold the sink off, which exposes append order and any state change during a stall. A directed run keeps port 0 on one line so that port 1's queue fills to 16. It then drains that queue and checks every entry by a sequence number carried in the offset, which catches lost, duplicated or reordered entries and a missing back-pressure signal.

// File: rtl/conflict_arb_pkg.sv
// Shared definitions for the line conflict arbiter.
// Assumes 32-bit byte addresses with 16-byte lines (offset in bits 3:0).
package conflict_arb_pkg;
    localparam int ADDR_W   = 32;
    localparam int LINE_LSB = 4;
    localparam int LINE_W   = ADDR_W - LINE_LSB;
    localparam int KIND_W   = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_READ   = 2'd0,
        KIND_WRITE  = 2'd1,
        KIND_RD_BC  = 2'd2,
        KIND_WR_BC  = 2'd3
    } req_kind_e;

    typedef struct packed {
        req_kind_e          kind;
        logic [ADDR_W-1:0]  addr;
    } mem_req_t;
endpackage

// File: rtl/arb_pend_queue.sv
// Private pending queue for one port: in-order storage of deferred requests.
// Assumes the caller never pushes while full nor pops while empty; push and
// pop may happen in the same cycle.
module arb_pend_queue #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 34,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Advance a pointer with wrap-around at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = store[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // Write the pushed entry into storage.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    // Keep pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/arb_line_resolve.sv
// Fixed-priority resolver: a candidate wins unless a lower-numbered port
// presents a candidate on the same line. Purely combinational.
module arb_line_resolve #(
    parameter int NPORT  = 4,
    parameter int LINE_W = 28
) (
    input  logic [NPORT-1:0]             cand_v,
    input  logic [NPORT-1:0][LINE_W-1:0] cand_line,
    output logic [NPORT-1:0]             win
);
    // Mark each candidate beaten by any higher-priority one on its line.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            win[p] = cand_v[p];
            for (int q = 0; q < p; q++) begin
                if (cand_v[q] && (cand_line[q] == cand_line[p])) win[p] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/line_conflict_arbiter.sv
// Line conflict arbiter: per-port candidate selection (queue head before new
// request), fixed-priority same-line resolution, and deferral of losers into
// private queues. Assumes the sink takes every valid lane when gnt_ready is high.
module line_conflict_arbiter
    import conflict_arb_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int QDEPTH = 16,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_valid,
    output logic [NPORT-1:0]          req_ready,
    input  logic [NPORT*KIND_W-1:0]   req_kind,
    input  logic [NPORT*ADDR_W-1:0]   req_addr,
    output logic [NPORT-1:0]          gnt_valid,
    input  logic                      gnt_ready,
    output logic [NPORT*KIND_W-1:0]   gnt_kind,
    output logic [NPORT*ADDR_W-1:0]   gnt_addr,
    output logic [NPORT*CNT_W-1:0]    occupancy
);
    localparam int REQ_W = $bits(mem_req_t);

    logic [NPORT-1:0]             cand_v;
    logic [NPORT-1:0][LINE_W-1:0] cand_line;
    logic [NPORT-1:0]             win;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            mem_req_t         new_req, head_req, cand;
            logic             q_empty, q_full, accept, push, pop;
            logic [CNT_W-1:0] q_count;

            // Unpack the port's incoming request.
            always_comb begin
                new_req.kind = req_kind_e'(req_kind[p*KIND_W +: KIND_W]);
                new_req.addr = req_addr[p*ADDR_W +: ADDR_W];
            end

            assign req_ready[p] = !q_full && gnt_ready;
            assign accept       = req_valid[p] && req_ready[p];
            assign cand         = q_empty ? new_req : head_req;
            assign cand_v[p]    = !q_empty || accept;
            assign cand_line[p] = cand.addr[ADDR_W-1:LINE_LSB];
            assign pop          = !q_empty && win[p] && gnt_ready;
            assign push         = accept && (!q_empty || !win[p]);

            arb_pend_queue #(.DEPTH(QDEPTH), .WIDTH(REQ_W)) u_queue (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push),
                .push_data (new_req),
                .pop       (pop),
                .head      (head_req),
                .empty     (q_empty),
                .full      (q_full),
                .count     (q_count)
            );

            assign gnt_valid[p]                 = win[p];
            assign gnt_kind[p*KIND_W +: KIND_W] = cand.kind;
            assign gnt_addr[p*ADDR_W +: ADDR_W] = cand.addr;
            assign occupancy[p*CNT_W +: CNT_W]  = q_count;

            assert_loser_queued_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid[p] && req_ready[p] && !gnt_valid[p])
                |=> (occupancy[p*CNT_W +: CNT_W] == $past(occupancy[p*CNT_W +: CNT_W]) + 1'b1));
            assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !gnt_ready |=> $stable(occupancy[p*CNT_W +: CNT_W]));
            assert_full_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (occupancy[p*CNT_W +: CNT_W] == CNT_W'(QDEPTH)) |-> !req_ready[p]);
        end
    endgenerate

    arb_line_resolve #(.NPORT(NPORT), .LINE_W(LINE_W)) u_resolve (
        .cand_v    (cand_v),
        .cand_line (cand_line),
        .win       (win)
    );

    generate
        for (genvar i = 0; i < NPORT; i++) begin : g_pair_a
            for (genvar j = i + 1; j < NPORT; j++) begin : g_pair_b
                assert_distinct_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    (gnt_valid[i] && gnt_valid[j]) |->
                    (gnt_addr[i*ADDR_W+LINE_LSB +: LINE_W] != gnt_addr[j*ADDR_W+LINE_LSB +: LINE_W]));
            end
        end
    endgenerate
endmodule

// File: tb/sim_line_conflict_arbiter.sv
module sim_line_conflict_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_valid = '0;
    logic [3:0]  req_ready;
    logic [7:0]  req_kind = '0;
    logic [127:0] req_addr = '0;
    logic [3:0]  gnt_valid;
    logic        gnt_ready = 1'b1;
    logic [7:0]  gnt_kind;
    logic [127:0] gnt_addr;
    logic [19:0] occupancy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_conflict_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .gnt_valid(gnt_valid),
        .gnt_ready(gnt_ready), .gnt_kind(gnt_kind), .gnt_addr(gnt_addr),
        .occupancy(occupancy)
    );

    typedef struct packed {
        logic [3:0] vld;
        logic [7:0] l0, l1, l2, l3;
        logic       grdy;
        logic [3:0] egv;
        logic [3:0] erdy;
        logic [4:0] o0, o1, o2, o3;
    } vec_t;

    // Stepped from reset; occupancies are the values after the clock edge.
    localparam vec_t TBL [9] = '{
        '{4'b1111, 8'd1, 8'd2, 8'd3, 8'd4, 1'b1, 4'b1111, 4'b1111, 5'd0, 5'd0, 5'd0, 5'd0},
        '{4'b1111, 8'd5, 8'd5, 8'd6, 8'd6, 1'b1, 4'b0101, 4'b1111, 5'd0, 5'd1, 5'd0, 5'd1},
        '{4'b0000, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1, 4'b1010, 4'b1111, 5'd0, 5'd0, 5'd0, 5'd0},
        '{4'b1111, 8'd7, 8'd7, 8'd7, 8'd7, 1'b1, 4'b0001, 4'b1111, 5'd0, 5'd1, 5'd1, 5'd1},
        '{4'b1111, 8'd8, 8'd9, 8'd10, 8'd11, 1'b1, 4'b0011, 4'b1111, 5'd0, 5'd1, 5'd2, 5'd2},
        '{4'b0000, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 4'b0110, 4'b0000, 5'd0, 5'd1, 5'd2, 5'd2},
        '{4'b0000, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1, 4'b0110, 4'b1111, 5'd0, 5'd0, 5'd1, 5'd2},
        '{4'b0000, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1, 4'b1100, 4'b1111, 5'd0, 5'd0, 5'd0, 5'd1},
        '{4'b0000, 8'd0, 8'd0, 8'd0, 8'd0, 1'b1, 4'b1000, 4'b1111, 5'd0, 5'd0, 5'd0, 5'd0}
    };

    function automatic logic [31:0] mk(input logic [7:0] line, input logic [3:0] off);
        return {20'h0, line, off};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] occ(input int p);
        return occupancy[p*5 +: 5];
    endfunction

    // R8: granted lanes never share a line.
    task automatic chk_distinct();
        bit ok = 1'b1;
        for (int i = 0; i < NP; i++)
            for (int j = i + 1; j < NP; j++)
                if (gnt_valid[i] && gnt_valid[j] &&
                    gnt_addr[i*32+4 +: 28] == gnt_addr[j*32+4 +: 28]) ok = 1'b0;
        chk(ok, "R8 distinct lines", {28'h0, gnt_valid}, {28'h0, gnt_valid});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        vec_t v;
        logic [7:0] lines [4];
        // Reset and R1 checks.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        chk(occupancy == '0, "R1 reset occupancy", {12'h0, occupancy}, 32'h0);
        chk(gnt_valid == '0, "R1 no grant after reset", {28'h0, gnt_valid}, 32'h0);
        chk(req_ready == 4'b1111, "R1 ready after reset", {28'h0, req_ready}, 32'hf);

        // Table walk: R2, R3, R4, R5, R7, R8.
        for (int k = 0; k < 9; k++) begin
            v = TBL[k];
            lines = '{v.l0, v.l1, v.l2, v.l3};
            @(negedge clk);
            req_valid = v.vld;
            gnt_ready = v.grdy;
            for (int p = 0; p < NP; p++) begin
                req_addr[p*32 +: 32] = mk(lines[p], 4'(p));
                req_kind[p*2 +: 2]   = 2'(3 - p);
            end
            #3;
            chk(gnt_valid == v.egv, $sformatf("R3 R5 grant lanes row %0d", k), {28'h0, gnt_valid}, {28'h0, v.egv});
            chk(req_ready == v.erdy, $sformatf("R7 ready row %0d", k), {28'h0, req_ready}, {28'h0, v.erdy});
            chk_distinct();
            if (k == 0) begin
                for (int p = 0; p < NP; p++) begin
                    chk(gnt_addr[p*32 +: 32] == mk(lines[p], 4'(p)), "R2 address pass-through",
                        gnt_addr[p*32 +: 32], mk(lines[p], 4'(p)));
                    chk(gnt_kind[p*2 +: 2] == 2'(3 - p), "R2 kind pass-through",
                        {30'h0, gnt_kind[p*2 +: 2]}, 32'(3 - p));
                end
            end
            @(posedge clk);
            #1;
            chk(occupancy == {v.o3, v.o2, v.o1, v.o0}, $sformatf("R4 R7 occupancy row %0d", k),
                {12'h0, occupancy}, {12'h0, v.o3, v.o2, v.o1, v.o0});
        end

        // Fill port 1 behind port 0 on line 20: R4, R6.
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            gnt_ready = 1'b1;
            req_valid = 4'b0011;
            req_addr[0 +: 32]  = mk(8'd20, 4'd0);
            req_addr[32 +: 32] = mk(8'd20, 4'(i));
            req_kind[2 +: 2]   = 2'(i);
            #3;
            chk(req_ready[1] == (i < 16), "R6 ready while filling", {31'h0, req_ready[1]}, 32'(i < 16));
            chk(gnt_valid == 4'b0001, "R3 port 0 wins shared line", {28'h0, gnt_valid}, 32'h1);
            @(posedge clk);
            #1;
            chk(occ(1) == 5'((i < 16) ? i + 1 : 16), "R6 occupancy capped", {27'h0, occ(1)},
                32'((i < 16) ? i + 1 : 16));
        end

        // Drain in order: R5, R9.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            req_valid = 4'b0000;
            #3;
            chk(gnt_valid == 4'b0010, "R9 drain lane", {28'h0, gnt_valid}, 32'h2);
            chk(gnt_addr[32 +: 4] == 4'(i), "R5 drain order", {28'h0, gnt_addr[32 +: 4]}, 32'(i));
            chk(gnt_kind[2 +: 2] == 2'(i), "R5 drained kind", {30'h0, gnt_kind[2 +: 2]}, 32'(i & 3));
            @(posedge clk);
            #1;
            chk(occ(1) == 5'(15 - i), "R9 drain occupancy", {27'h0, occ(1)}, 32'(15 - i));
        end
        @(negedge clk);
        #3;
        chk(gnt_valid == 4'b0000, "R9 no extra grant", {28'h0, gnt_valid}, 32'h0);
        chk(occupancy == '0, "R9 queues empty", {12'h0, occupancy}, 32'h0);

        // Reset mid-traffic returns to the idle state: R1.
        req_valid = 4'b1111;
        for (int p = 0; p < NP; p++) req_addr[p*32 +: 32] = mk(8'd30, 4'(p));
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 4'b0000;
        @(posedge clk);
        #1;
        chk(occupancy == '0, "R1 occupancy after second reset", {12'h0, occupancy}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule